// File: doc/BRIEF.md
# Angular Intra Reference Array and Row Index Generator

This block prepares everything an angular intra prediction datapath needs before it can interpolate. From a mode number in 2..34, a block size of 4, 8, 16 or 32, one corner sample and two neighbour rows (the samples above the block and the samples to its left, 2N-deep each), it assembles a single linear reference array. The mode decides which neighbour row becomes the main side. For negative prediction angles, the leading slots are filled with samples projected from the other side.

After the array is captured, the block walks the rows of the block one per clock. For each row it emits the integer step into the array and the 1/32 interpolation weight. It flags rows whose weight is zero, because those rows copy reference samples directly. A one-cycle completion pulse follows the final row. Sample filtering and substitution of missing neighbours are done elsewhere.

The angle for each mode comes from a fixed internal table. A start request is taken only while no row walk is running and only for a legal mode.

Top module: `angRefIdxGen`

## Requirements
- R1: After reset, `rowValid` and `done` are low and every slot of `refOut` is zero.
- R2: `refOut` holds 97 slots of W bits, with slot j at bits [j*W +: W] and logical position x = j-32. Slot x=0 holds the corner sample. Slots x=1..2N hold main-side sample x-1, where the main side is the above row for modes 18 and up and the left column for modes below 18. Slots x>2N are zero.
- R3: When the captured mode's angle is zero or positive, the reserved slots x=-1..-32 are all zero.
- R4: When the angle a is negative, let k=-x and L=-((N*a)>>>5). Each slot with k<=L holds the opposite-side sample at m=(k*inv+128)>>8, where inv=(8192+|a|/2)/|a|, m=0 selects the corner and m>=1 selects opposite sample m-1. Slots with k>L are zero.
- R5: The angle per mode is 32,26,21,17,13,9,5,2,0,-2,-5,-9,-13,-17,-21,-26,-32 for modes 2..18, and -26,-21,-17,-13,-9,-5,-2,0,2,5,9,13,17,21,26,32 for modes 19..34.
- R6: After an accepted start, rows 0..N-1 are issued on consecutive cycles with `rowValid` high, beginning one clock after the start.
- R7: For row y, `rowOffset` equals ((y+1)*a)>>>5 as a signed value and `rowWeight` equals ((y+1)*a)&31.
- R8: `rowCopy` is high exactly when `rowWeight` is zero.
- R9: `done` is high for exactly one cycle, in the cycle right after the last row, with `rowValid` low.
- R10: A start raised while rows are being issued is ignored: the rows continue unchanged and `refOut` keeps its contents.
- R11: A start with a mode outside 2..34 is ignored: `rowValid` stays low and `refOut` is unchanged.
- R12: `refOut` changes only on an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to capture a new mode and neighbour set |
| modeIn | input | 6 | Angular mode number, legal range 2..34 |
| sizeSel | input | 2 | Block size code: N = 4 << sizeSel |
| cornerIn | input | W | Sample diagonally above-left of the block |
| aboveIn | input | 64*W | Above neighbours, sample i at [i*W +: W] |
| leftIn | input | 64*W | Left neighbours, sample i at [i*W +: W] |
| refOut | output | 97*W | Captured reference array (layout in R2) |
| rowValid | output | 1 | Row outputs carry a valid row |
| rowIdx | output | 5 | Index of the current row |
| rowOffset | output | 7 | Signed integer step into the reference array |
| rowWeight | output | 5 | Fractional weight in 1/32 units |
| rowCopy | output | 1 | Row needs no interpolation |
| done | output | 1 | One-cycle pulse after the last row |

## Verification
An accepted start becomes visible one rising edge later: `refOut` and row 0 appear together. Row y follows y+1 edges after the start, and `done` follows N+1 edges after it. The bench drives inputs on falling edges and samples every output at the falling edge in the middle of the cycle in which it is due, stepping one falling edge per row. Starts that should be ignored are followed by a check one edge later, which confirms that the row stream and the reference array look exactly as they would without the request.

// File: rtl/angRefPkg.sv
package angRefPkg;
  localparam int MAXN     = 32;
  localparam int SIDE_LEN = 2 * MAXN;
  localparam int NSLOT    = 3 * MAXN + 1;
  localparam int ANG_W    = 7;
  localparam int ACC_W    = 12;
  localparam int OFF_W    = 7;
  localparam int INV_W    = 13;
  localparam int ROW_W    = $clog2(MAXN);

  typedef struct packed {
    logic load;
    logic step;
  } ctlStrobes_t;

  function automatic logic modeOk(input logic [5:0] m);
    return (m >= 6'd2) && (m <= 6'd34);
  endfunction

  // magnitude of the angle by distance from the pure horizontal/vertical mode
  function automatic logic [5:0] angleMag(input logic [3:0] d);
    case (d)
      4'd0: return 6'd0;
      4'd1: return 6'd2;
      4'd2: return 6'd5;
      4'd3: return 6'd9;
      4'd4: return 6'd13;
      4'd5: return 6'd17;
      4'd6: return 6'd21;
      4'd7: return 6'd26;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic signed [ANG_W-1:0] modeAngle(input logic [5:0] m);
    logic [5:0] d;
    logic neg;
    logic signed [ANG_W-1:0] mag;
    if (m < 6'd18) begin
      if (m <= 6'd10) begin d = 6'd10 - m; neg = 1'b0; end
      else begin d = m - 6'd10; neg = 1'b1; end
    end else if (m < 6'd26) begin
      d = 6'd26 - m; neg = 1'b1;
    end else begin
      d = m - 6'd26; neg = 1'b0;
    end
    mag = $signed({1'b0, angleMag(4'(d))});
    return neg ? -mag : mag;
  endfunction

  // rounded 8192 / |angle|
  function automatic logic [INV_W-1:0] invMag(input logic [5:0] mag);
    case (mag)
      6'd2:  return 13'd4096;
      6'd5:  return 13'd1638;
      6'd9:  return 13'd910;
      6'd13: return 13'd630;
      6'd17: return 13'd482;
      6'd21: return 13'd390;
      6'd26: return 13'd315;
      6'd32: return 13'd256;
      default: return 13'd0;
    endcase
  endfunction
endpackage

// File: rtl/angRefControl.sv
module angRefControl
  import angRefPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [5:0]       modeIn,
  input  logic [1:0]       sizeSel,
  output ctlStrobes_t      ctl,
  output logic             rowValid,
  output logic [ROW_W-1:0] rowIdx,
  output logic             done
);
  logic [ROW_W-1:0] lastRow;
  logic [6:0]       nRows;
  logic             accept;

  assign nRows  = 7'd4 << sizeSel;
  assign accept = start && !rowValid && modeOk(modeIn);

  assign ctl.load = accept;
  assign ctl.step = rowValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowValid <= 1'b0;
      rowIdx   <= '0;
      lastRow  <= '0;
      done     <= 1'b0;
    end else if (accept) begin
      rowValid <= 1'b1;
      rowIdx   <= '0;
      lastRow  <= ROW_W'(nRows - 7'd1);
      done     <= 1'b0;
    end else if (rowValid) begin
      if (rowIdx == lastRow) begin
        rowValid <= 1'b0;
        done     <= 1'b1;
      end else begin
        rowIdx   <= rowIdx + 1'b1;
        done     <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  // R6: first row follows an accepted start
  p_first_row_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (rowValid && rowIdx == '0));

  // R6: consecutive rows, one per clock
  p_row_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rowValid && rowIdx != lastRow) |=> (rowValid && rowIdx == $past(rowIdx) + 1'b1));

  // R9: done right after the last row
  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rowValid && rowIdx == lastRow) |=> (done && !rowValid));

  // R9: done lasts a single cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/angRefDatapath.sv
module angRefDatapath
  import angRefPkg::*;
#(
  parameter int W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobes_t             ctl,
  input  logic [5:0]              modeIn,
  input  logic [1:0]              sizeSel,
  input  logic [W-1:0]            cornerIn,
  input  logic [SIDE_LEN*W-1:0]   aboveIn,
  input  logic [SIDE_LEN*W-1:0]   leftIn,
  output logic [NSLOT*W-1:0]      refOut,
  output logic signed [OFF_W-1:0] rowOffset,
  output logic [4:0]              rowWeight,
  output logic                    rowCopy
);
  logic signed [ANG_W-1:0] angleIn;
  logic                    angNeg;
  logic [5:0]              angMag;
  logic [INV_W-1:0]        invIn;
  logic [6:0]              nSize;
  logic [6:0]              sideLim;
  logic [12:0]             spanProd;
  logic [12:0]             kLimit;
  logic                    useAbove;

  assign angleIn  = modeAngle(modeIn);
  assign angNeg   = angleIn[ANG_W-1];
  assign angMag   = 6'(angNeg ? -angleIn : angleIn);
  assign invIn    = invMag(angMag);
  assign nSize    = 7'd4 << sizeSel;
  assign sideLim  = nSize << 1;
  assign spanProd = {6'b0, nSize} * {7'b0, angMag} + 13'd31;
  assign kLimit   = spanProd >> 5;
  assign useAbove = (modeIn >= 6'd18);

  logic [W-1:0] mainArr [SIDE_LEN];
  logic [W-1:0] oppArr  [SIDE_LEN];

  for (genvar i = 0; i < SIDE_LEN; i++) begin : g_side
    assign mainArr[i] = useAbove ? aboveIn[i*W +: W] : leftIn[i*W +: W];
    assign oppArr[i]  = useAbove ? leftIn[i*W +: W]  : aboveIn[i*W +: W];
  end

  logic [NSLOT-1:0][W-1:0] nextRef;
  logic [NSLOT-1:0][W-1:0] refArr;

  for (genvar j = 0; j < NSLOT; j++) begin : g_slot
    localparam int X = j - MAXN;
    if (X == 0) begin : g_corner
      assign nextRef[j] = cornerIn;
    end else if (X > 0) begin : g_main
      assign nextRef[j] = (7'(X) <= sideLim) ? mainArr[X-1] : '0;
    end else begin : g_proj
      localparam int K = -X;
      logic [19:0]  projSum;
      logic [19:0]  projIdx;
      logic [5:0]   oppSel;
      logic [W-1:0] projVal;
      assign projSum = 20'(K) * 20'(invIn) + 20'd128;
      assign projIdx = projSum >> 8;
      assign oppSel  = 6'(projIdx - 20'd1);
      always_comb begin
        projVal = '0;
        if (angNeg && (13'(K) <= kLimit)) begin
          if (projIdx == 20'd0)                projVal = cornerIn;
          else if (projIdx <= 20'(SIDE_LEN))   projVal = oppArr[oppSel];
        end
      end
      assign nextRef[j] = projVal;
    end
  end

  logic signed [ANG_W-1:0] angleReg;
  logic signed [ACC_W-1:0] accReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refArr   <= '0;
      angleReg <= '0;
      accReg   <= '0;
    end else if (ctl.load) begin
      refArr   <= nextRef;
      angleReg <= angleIn;
      accReg   <= {{(ACC_W-ANG_W){angleIn[ANG_W-1]}}, angleIn};
    end else if (ctl.step) begin
      accReg   <= accReg + {{(ACC_W-ANG_W){angleReg[ANG_W-1]}}, angleReg};
    end
  end

  assign refOut    = refArr;
  assign rowOffset = OFF_W'(accReg >>> 5);
  assign rowWeight = accReg[4:0];
  assign rowCopy   = (rowWeight == 5'd0);

  // R12: array only moves on a load strobe
  p_ref_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(refArr));

  // R2: corner slot taken from the corner input at load
  p_load_corner_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (refArr[MAXN] == $past(cornerIn)));

  // R3: reserved slots stay clear for non-negative angles
  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    !angleReg[ANG_W-1] |-> (refArr[MAXN-1:0] == '0));

  // R7: each row step advances the product by the angle
  p_acc_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> ((accReg - $past(accReg)) == {{(ACC_W-ANG_W){angleReg[ANG_W-1]}}, angleReg}));
endmodule

// File: rtl/angRefIdxGen.sv
module angRefIdxGen
  import angRefPkg::*;
#(
  parameter int W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [5:0]              modeIn,
  input  logic [1:0]              sizeSel,
  input  logic [W-1:0]            cornerIn,
  input  logic [SIDE_LEN*W-1:0]   aboveIn,
  input  logic [SIDE_LEN*W-1:0]   leftIn,
  output logic [NSLOT*W-1:0]      refOut,
  output logic                    rowValid,
  output logic [ROW_W-1:0]        rowIdx,
  output logic signed [OFF_W-1:0] rowOffset,
  output logic [4:0]              rowWeight,
  output logic                    rowCopy,
  output logic                    done
);
  ctlStrobes_t ctl;

  angRefControl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .modeIn   (modeIn),
    .sizeSel  (sizeSel),
    .ctl      (ctl),
    .rowValid (rowValid),
    .rowIdx   (rowIdx),
    .done     (done)
  );

  angRefDatapath #(.W(W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .modeIn    (modeIn),
    .sizeSel   (sizeSel),
    .cornerIn  (cornerIn),
    .aboveIn   (aboveIn),
    .leftIn    (leftIn),
    .refOut    (refOut),
    .rowOffset (rowOffset),
    .rowWeight (rowWeight),
    .rowCopy   (rowCopy)
  );
endmodule

// File: tb/angRefIdxGen_test.sv
module angRefIdxGen_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int SIDE = 64;
  localparam int SLOTS = 97;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [5:0] modeIn = '0;
  logic [1:0] sizeSel = '0;
  logic [W-1:0] cornerIn = '0;
  logic [SIDE*W-1:0] aboveIn = '0;
  logic [SIDE*W-1:0] leftIn = '0;
  logic [SLOTS*W-1:0] refOut;
  logic rowValid;
  logic [4:0] rowIdx;
  logic signed [6:0] rowOffset;
  logic [4:0] rowWeight;
  logic rowCopy;
  logic done;

  always #(CLK_PERIOD/2) clk = ~clk;

  angRefIdxGen #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeIn), .sizeSel(sizeSel),
    .cornerIn(cornerIn), .aboveIn(aboveIn), .leftIn(leftIn), .refOut(refOut),
    .rowValid(rowValid), .rowIdx(rowIdx), .rowOffset(rowOffset),
    .rowWeight(rowWeight), .rowCopy(rowCopy), .done(done)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  int angTbl [33] = '{32,26,21,17,13,9,5,2,0,-2,-5,-9,-13,-17,-21,-26,-32,
                      -26,-21,-17,-13,-9,-5,-2,0,2,5,9,13,17,21,26,32};
  int abv [SIDE];
  int lft [SIDE];
  int crn;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R5 table lookup
  function automatic int benchAngle(input int m);
    return angTbl[m-2];
  endfunction

  // R2, R3, R4 expected slot contents
  function automatic int expSlot(input int j, input int mode, input int n);
    int x, a, k, lim, inv, m, mag;
    x = j - 32;
    a = benchAngle(mode);
    if (x == 0) return crn;
    if (x > 0) begin
      if (x > 2*n) return 0;
      return (mode >= 18) ? abv[x-1] : lft[x-1];
    end
    if (a >= 0) return 0;
    k = -x;
    lim = -((n * a) >>> 5);
    if (k > lim) return 0;
    mag = -a;
    inv = (8192 + mag/2) / mag;
    m = (k * inv + 128) >> 8;
    if (m == 0) return crn;
    if (m > 2*n && m > SIDE) return 0;
    return (mode >= 18) ? lft[m-1] : abv[m-1];
  endfunction

  task automatic checkRef(input int mode, input int n, input string req);
    int bad = 0;
    int firstAct = 0;
    int firstExp = 0;
    for (int j = 0; j < SLOTS; j++) begin
      int e = expSlot(j, mode, n);
      int act = int'(refOut[j*W +: W]);
      if (act != e) begin
        if (bad == 0) begin firstAct = act; firstExp = e; end
        bad++;
      end
    end
    check(bad == 0, req, firstAct, firstExp);
  endtask

  task automatic randNeighbours();
    crn = int'($urandom_range(0, 255));
    cornerIn = W'(crn);
    for (int i = 0; i < SIDE; i++) begin
      abv[i] = int'($urandom_range(0, 255));
      lft[i] = int'($urandom_range(0, 255));
      aboveIn[i*W +: W] = W'(abv[i]);
      leftIn[i*W +: W] = W'(lft[i]);
    end
  endtask

  // run one accepted case; intrAt >= 0 raises a stray start at that row (R10)
  task automatic runCase(input int mode, input int ssel, input int intrAt);
    int n = 4 << ssel;
    int a = benchAngle(mode);
    @(negedge clk);
    modeIn = 6'(mode);
    sizeSel = 2'(ssel);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    checkRef(mode, n, (a < 0) ? "R4 projected array" : "R2 R3 array");
    for (int y = 0; y < n; y++) begin
      int p = (y + 1) * a;
      int eo = p >>> 5;
      int ew = p & 31;
      check(rowValid && int'(rowIdx) == y, "R6 row sequence", int'(rowIdx), y);
      check(int'(rowOffset) == eo, "R7 offset", int'(rowOffset), eo);
      check(int'(rowWeight) == ew, "R7 weight", int'(rowWeight), ew);
      check(rowCopy == (ew == 0), "R8 copy flag", int'(rowCopy), int'(ew == 0));
      if (y == intrAt) begin
        modeIn = 6'((mode == 18) ? 2 : 18);
        sizeSel = 2'(ssel ^ 1);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(done && !rowValid, "R9 done after last row", int'(done), 1);
    if (intrAt >= 0) checkRef(mode, n, "R10 array kept");
    @(negedge clk);
    check(!done, "R9 done single cycle", int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    randNeighbours();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!rowValid, "R1 rowValid at reset", int'(rowValid), 0);
    check(!done, "R1 done at reset", int'(done), 0);
    check(refOut == '0, "R1 refOut at reset", 0, 0);
    rowN_release();

    // directed: every mode, sizes rotating
    for (int m = 2; m <= 34; m++) begin
      randNeighbours();
      runCase(m, m % 4, -1);
    end
    // corners: steepest negative and shallowest negative at 32, zero angles
    randNeighbours(); runCase(18, 3, -1);
    randNeighbours(); runCase(11, 3, -1);
    randNeighbours(); runCase(25, 3, -1);
    randNeighbours(); runCase(10, 2, -1);
    randNeighbours(); runCase(26, 0, -1);
    randNeighbours(); runCase(2, 3, -1);
    // R10: stray start during the row walk
    randNeighbours(); runCase(14, 1, 3);
    randNeighbours(); runCase(30, 0, 0);

    // R11: illegal modes leave everything untouched
    for (int t = 0; t < 4; t++) begin
      int bad = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 35 : 63;
      @(negedge clk);
      modeIn = 6'(bad);
      sizeSel = 2'd3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(!rowValid, "R11 illegal mode rejected", int'(rowValid), 0);
      checkRef(30, 4, "R11 R12 array unchanged");
    end

    // constrained random
    for (int r = 0; r < 40; r++) begin
      randNeighbours();
      runCase(int'($urandom_range(2, 34)), int'($urandom_range(0, 3)), -1);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic rowN_release();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule